// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Bus

The block gathers a parameterised number of interrupt request lines, up to 32, and records each request in a status register. Each line is either edge sensitive (a rising transition is latched) or level sensitive (the line is latched on every cycle it is high). A parameter bit mask picks the kind for each line. Latched requests are gated by an enable register. The result is folded into a single interrupt line for a processor. A vector register names the lowest-numbered input that is both latched and enabled.

Software works the block through a simple 32-bit register bus. Each access has a byte address, of which the low two bits are ignored, and one write strobe. Reads return data combinationally. Enables can be rewritten whole, or changed bit by bit through separate set and clear registers, so no read-modify-write is needed. Latched requests are cleared by writing ones to an acknowledge register. A two-bit master register must have both bits at 1 before the output can assert. Its upper bit alone controls whether the input lines are latched at all.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the status, enable and master registers read 0, the vector register reads 0xFFFFFFFF and `irq_out` is low.
- R2: A level-sensitive input sets its status bit on every clock edge at which it is high. An acknowledge written while the line stays high leaves the bit set, and an acknowledge after the line drops clears it.
- R3: An edge-sensitive input (mask bit 1; here bits 4 to 7 of an 8-input build) sets its status bit only on a low-to-high transition. An acknowledge while the line is held high clears the bit for good until the next rising transition.
- R4: Writing the acknowledge register (offset 0x0C) clears each status bit written as 1 and leaves the bits written as 0 unchanged. A new request in the same cycle wins over the clear.
- R5: A write to the enable register (offset 0x08) replaces every enable bit. Writing 0 masks all inputs while the status register keeps its latched bits.
- R6: A write to the set-enable register (offset 0x10) sets the enable bits written as 1. A write to the clear-enable register (offset 0x14) clears the enable bits written as 1. All other enable bits keep their value.
- R7: The pending register (offset 0x04) reads as status AND enable.
- R8: The vector register (offset 0x18) reads the index of the lowest set pending bit, or 0xFFFFFFFF when no bit is pending.
- R9: `irq_out` is high exactly when master bits 0 and 1 (offset 0x1C) are both 1 and at least one pending bit is 1.
- R10: While master bit 1 is 0, no input sets a status bit. Already latched bits remain until acknowledged.
- R11: Status sits at offset 0x00. The acknowledge, set-enable, clear-enable and all unused offsets read 0. Writes to status, pending, vector and unused offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | NUM_IN | Interrupt request lines, synchronous to clk |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | 1 | Combined interrupt to the processor |

## Verification
The assertions take for granted that `irq_in` is already synchronous to `clk`, and that the bus address and strobe are never unknown after reset. The edge and level rules are stated against the input value sampled at the previous edge, which only holds for clean synchronous lines. The bench changes every input on the falling clock edge and samples the combinational read data a short delay later. This keeps each request and each write tied to one known rising edge. It sweeps all 256 request patterns of an 8-input build against varying enable masks.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int unsigned DATA_W = 32;

  // Word index of each register (byte offset / 4).
  typedef enum logic [2:0] {
    RS_STAT  = 3'd0,
    RS_PEND  = 3'd1,
    RS_ENAB  = 3'd2,
    RS_ACK   = 3'd3,
    RS_SETEN = 3'd4,
    RS_CLREN = 3'd5,
    RS_VEC   = 3'd6,
    RS_MER   = 3'd7
  } irqc_reg_e;

  localparam int unsigned MER_OUT_BIT = 0;
  localparam int unsigned MER_HW_BIT  = 1;

endpackage

// File: rtl/irqc_capture.sv
module irqc_capture #(
  parameter int unsigned NUM_IN    = 32,
  parameter logic [31:0] EDGE_MASK = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] irq_in,
  input  logic              hw_en,
  output logic [NUM_IN-1:0] set_vec
);

  logic [NUM_IN-1:0] prev_q;
  logic [NUM_IN-1:0] prev_d;

  always_comb begin
    prev_d = irq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= prev_d;
    end
  end

  for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_kind
    if (EDGE_MASK[gi]) begin : g_edge
      assign set_vec[gi] = hw_en & irq_in[gi] & ~prev_q[gi];
    end else begin : g_level
      assign set_vec[gi] = hw_en & irq_in[gi];
    end
  end

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_IN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              hit,
  input  irqc_reg_e         reg_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_IN-1:0] set_vec,
  output logic [NUM_IN-1:0] status,
  output logic [NUM_IN-1:0] enable,
  output logic [1:0]        mer
);

  logic              wr_hit;
  logic [NUM_IN-1:0] wbits;
  logic [NUM_IN-1:0] ack_clr;
  logic [NUM_IN-1:0] status_d;
  logic [NUM_IN-1:0] enable_d;
  logic [1:0]        mer_d;
  logic              status_ce;
  logic              enable_ce;
  logic              mer_ce;

  always_comb begin
    wr_hit    = wr_en & hit;
    wbits     = wdata[NUM_IN-1:0];
    ack_clr   = (wr_hit && reg_sel == RS_ACK) ? wbits : '0;
    // New requests take precedence over a clear in the same cycle.
    status_d  = (status & ~ack_clr) | set_vec;
    status_ce = (|ack_clr) | (|set_vec);

    enable_d  = enable;
    enable_ce = 1'b0;
    if (wr_hit) begin
      unique case (reg_sel)
        RS_ENAB: begin
          enable_d  = wbits;
          enable_ce = 1'b1;
        end
        RS_SETEN: begin
          enable_d  = enable | wbits;
          enable_ce = 1'b1;
        end
        RS_CLREN: begin
          enable_d  = enable & ~wbits;
          enable_ce = 1'b1;
        end
        default: begin
          enable_d  = enable;
          enable_ce = 1'b0;
        end
      endcase
    end

    mer_ce = wr_hit && (reg_sel == RS_MER);
    mer_d  = wdata[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
    end else if (status_ce) begin
      status <= status_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= '0;
    end else if (enable_ce) begin
      enable <= enable_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mer <= '0;
    end else if (mer_ce) begin
      mer <= mer_d;
    end
  end

  // R6
  set_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit && reg_sel == RS_SETEN) |=>
      ((enable & $past(wdata[NUM_IN-1:0])) == $past(wdata[NUM_IN-1:0])));

  // R6
  clear_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit && reg_sel == RS_CLREN) |=>
      ((enable & $past(wdata[NUM_IN-1:0])) == '0));

  // R10
  no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mer[MER_HW_BIT]) |=> ((status & ~$past(status)) == '0));

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int unsigned NUM_IN = 32,
  localparam int unsigned IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic [NUM_IN-1:0] pending,
  output logic              vec_valid,
  output logic [IDX_W-1:0]  vec_idx
);

  always_comb begin
    vec_valid = 1'b0;
    vec_idx   = '0;
    // Scan downward so the lowest set index is written last.
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (pending[i]) begin
        vec_valid = 1'b1;
        vec_idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_IN    = 32,
  parameter logic [31:0] EDGE_MASK = 32'h0,
  parameter int unsigned ADDR_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] irq_in,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_out
);

  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam int unsigned IDX_W  = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic [WORD_W-1:0] word_idx;
  logic              hit;
  irqc_reg_e         reg_sel;
  logic [NUM_IN-1:0] set_vec;
  logic [NUM_IN-1:0] stat_q;
  logic [NUM_IN-1:0] enab_q;
  logic [1:0]        mer_q;
  logic [NUM_IN-1:0] pending;
  logic              vec_valid;
  logic [IDX_W-1:0]  vec_idx;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  always_comb begin
    word_idx = bus_addr[ADDR_W-1:2];
    hit      = (word_idx < WORD_W'(8));
    reg_sel  = irqc_reg_e'(word_idx[2:0]);
  end

  irqc_capture #(
    .NUM_IN    (NUM_IN),
    .EDGE_MASK (EDGE_MASK)
  ) u_capture (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .irq_in  (irq_in),
    .hw_en   (mer_q[MER_HW_BIT]),
    .set_vec (set_vec)
  );

  irqc_regs #(
    .NUM_IN (NUM_IN)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (bus_wr),
    .hit     (hit),
    .reg_sel (reg_sel),
    .wdata   (bus_wdata),
    .set_vec (set_vec),
    .status  (stat_q),
    .enable  (enab_q),
    .mer     (mer_q)
  );

  assign pending = stat_q & enab_q;

  irqc_prio #(
    .NUM_IN (NUM_IN)
  ) u_prio (
    .pending   (pending),
    .vec_valid (vec_valid),
    .vec_idx   (vec_idx)
  );

  assign irq_out = mer_q[MER_OUT_BIT] & mer_q[MER_HW_BIT] & vec_valid;

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      unique case (reg_sel)
        RS_STAT: bus_rdata = 32'(stat_q);
        RS_PEND: bus_rdata = 32'(pending);
        RS_ENAB: bus_rdata = 32'(enab_q);
        RS_VEC:  bus_rdata = vec_valid ? 32'(vec_idx) : 32'hFFFF_FFFF;
        RS_MER:  bus_rdata = {30'd0, mer_q};
        default: bus_rdata = '0;
      endcase
    end
  end

  // R8
  vec_points_pending_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    vec_valid |-> pending[vec_idx]);

  // R8
  vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pending == '0) |-> !vec_valid);

  // R9
  out_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_out |-> (vec_valid && mer_q == 2'b11));

  for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_rise_chk
    // R2 R3
    status_source_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $rose(stat_q[gi]) |-> $past(irq_in[gi]));
  end

endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;

  localparam int NI = 8;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NI-1:0] irq_in = '0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  irq_vector_ctrl #(
    .NUM_IN    (NI),
    .EDGE_MASK (32'hFFFF_FFF0),
    .ADDR_W    (AW)
  ) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out)
  );

  localparam logic [AW-1:0] A_STAT = 6'h00, A_PEND = 6'h04, A_ENAB = 6'h08,
    A_ACK = 6'h0C, A_SET = 6'h10, A_CLR = 6'h14, A_VEC = 6'h18, A_MER = 6'h1C,
    A_UNUSED = 6'h24;

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] lowest(input logic [NI-1:0] p);
    for (int i = 0; i < NI; i++) if (p[i]) return 32'(i);
    return 32'hFFFF_FFFF;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(A_STAT, d); chk(d, 0, "R1 status");
    rd(A_ENAB, d); chk(d, 0, "R1 enable");
    rd(A_MER, d);  chk(d, 0, "R1 master");
    rd(A_VEC, d);  chk(d, 32'hFFFF_FFFF, "R1 vector");
    chk(32'(irq_out), 0, "R1 irq_out");

    // R10 no capture while hardware bit is 0
    @(negedge clk); irq_in = 8'hFF;
    repeat (2) @(negedge clk);
    rd(A_STAT, d); chk(d, 0, "R10 gated capture");
    wr(A_MER, 32'h3);
    rd(A_MER, d); chk(d, 3, "R11 master readback");
    @(negedge clk);
    // level bits latch, edge bits saw no new rise (R3)
    rd(A_STAT, d); chk(d, 32'h0F, "R3 held edge no rise");
    irq_in = 8'h00;
    wr(A_ACK, 32'hFF);
    rd(A_STAT, d); chk(d, 0, "R4 ack all");

    // R2 level re-latch while high
    irq_in = 8'h01;
    @(negedge clk);
    wr(A_ACK, 32'h01);
    rd(A_STAT, d); chk(d, 32'h01, "R2 ack while high");
    irq_in = 8'h00;
    @(negedge clk);
    wr(A_ACK, 32'h01);
    rd(A_STAT, d); chk(d, 0, "R2 ack after drop");

    // R3 edge: ack while held stays clear; new rise sets
    irq_in = 8'h10;
    @(negedge clk);
    rd(A_STAT, d); chk(d, 32'h10, "R3 rise latched");
    wr(A_ACK, 32'h10);
    repeat (2) @(negedge clk);
    rd(A_STAT, d); chk(d, 0, "R3 held after ack");
    irq_in = 8'h00;
    @(negedge clk); irq_in = 8'h10;
    @(negedge clk);
    rd(A_STAT, d); chk(d, 32'h10, "R3 second rise");
    irq_in = 8'h00;

    // R4 zeros in ack leave bits; R5 enable zero keeps status
    @(negedge clk); irq_in = 8'h22;
    @(negedge clk); irq_in = 8'h00;
    wr(A_ACK, 32'h02);
    rd(A_STAT, d); chk(d, 32'h30, "R4 partial ack");
    wr(A_ENAB, 32'hFF);
    wr(A_ENAB, 32'h00);
    rd(A_STAT, d); chk(d, 32'h30, "R5 status kept");
    rd(A_PEND, d); chk(d, 0, "R5 all masked");
    chk(32'(irq_out), 0, "R9 masked out");

    // R11 read-only writes and unused offsets
    wr(A_STAT, 32'h0F); wr(A_PEND, 32'hFF); wr(A_VEC, 32'h3);
    wr(A_UNUSED, 32'hFF);
    rd(A_STAT, d); chk(d, 32'h30, "R11 status write ignored");
    rd(A_ENAB, d); chk(d, 0, "R11 unused write ignored");
    rd(A_ACK, d); chk(d, 0, "R11 ack reads zero");
    rd(A_SET, d); chk(d, 0, "R11 set reads zero");
    rd(A_CLR, d); chk(d, 0, "R11 clr reads zero");
    rd(A_UNUSED, d); chk(d, 0, "R11 unused reads zero");

    // R9 master bit combinations with pending bit 4
    wr(A_ENAB, 32'h10);
    for (int m = 0; m < 4; m++) begin
      wr(A_MER, 32'(m));
      chk(32'(irq_out), (m == 3) ? 1 : 0, "R9 master gate");
    end
    wr(A_ACK, 32'hFF);

    // R6 set/clear enable sweep
    for (int e = 0; e < 256; e++) begin
      wr(A_ENAB, 32'h5A);
      wr(A_SET, 32'(e));
      rd(A_ENAB, d); chk(d, 32'(e) | 32'h5A, "R6 set-enable");
      wr(A_CLR, 32'(e));
      rd(A_ENAB, d); chk(d, 32'h5A & ~32'(e), "R6 clear-enable");
    end

    // R7 R8 R9 exhaustive request patterns
    for (int p = 0; p < 256; p++) begin
      logic [NI-1:0] en;
      logic [NI-1:0] pend;
      en   = NI'((p * 37 + 11) & 8'hFF);
      pend = NI'(p) & en;
      wr(A_ENAB, 32'(en));
      irq_in = NI'(p);
      @(negedge clk);
      rd(A_STAT, d); chk(d, 32'(p), "R2 R3 status pattern");
      rd(A_PEND, d); chk(d, 32'(pend), "R7 pending");
      rd(A_VEC, d);  chk(d, lowest(pend), "R8 vector");
      chk(32'(irq_out), 32'(pend != 0), "R9 irq_out");
      irq_in = '0;
      wr(A_ACK, 32'hFF);
      rd(A_STAT, d); chk(d, 0, "R4 cleared");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule